// File: doc/BRIEF.md
# Receive Frame Descriptor Writer

This block sits between a byte-wide receive stream and a descriptor ring in system memory. When a frame begins, it reads the descriptor under its ring pointer through a simple word-wide memory master: an ownership word, a size word and a buffer address. It then copies the frame bytes into that buffer as little-endian words with per-byte enables. Finally it hands the descriptor back by writing a completion word that carries the frame length plus four CRC bytes.

After a completed frame the ring pointer steps to the next 32-byte descriptor, or it returns to the ring base when the descriptor asks for that. Four sticky status bits report receive completion, the normal summary, a missing descriptor and the abnormal summary, and software clears them by writing ones. Each accepted frame is classed by its destination address as unicast, multicast or broadcast, and wrapping 32-bit counters record frames, bytes and the two group classes.

The ring base is loaded by a pulse, and that pulse also moves the pointer to the base. A receive-enable input, sampled when a frame starts, decides whether the frame is taken or thrown away.

Top module: `rxd_writer`

## Requirements
- R1: A frame whose first byte arrives while `rx_en_i` is low is consumed from the stream and thrown away. It causes no memory request and changes no status bit, counter or pointer.
- R2: A frame shorter than 12 bytes sets status bits 0 (receive done) and 1 (normal summary). Its descriptor word 0 is not written, and the pointer and counters stay unchanged. This holds whether or not a descriptor was available.
- R3: When bit 31 of descriptor word 0 (offset 0) is clear and the frame has at least 12 bytes, the frame is discarded and status bits 2 (no descriptor) and 3 (abnormal summary) are set. Word 0, the pointer and the counters are left unchanged.
- R4: A completed frame writes word 0 of its descriptor with ((length + 4) mod 2^14) in bits 29:16, bits 9 and 8 set, and all other bits zero, so the ownership bit 31 is cleared.
- R5: Frame byte i goes to byte address buffer + i, where the buffer address is descriptor word 2 (offset 8). It is written as byte lane i mod 4 of the aligned word.
- R6: The buffer size is bits 11:0 of descriptor word 1 (offset 4). Bytes at index size and above are not written to memory, and the reported length still counts the full frame.
- R7: After a completed frame the pointer advances by 32. If bit 15 of descriptor word 1 is set, the pointer reloads the ring base instead.
- R8: A completed frame whose six first bytes are all 0xFF counts as broadcast. Otherwise, if bit 0 of its first byte is 1, it counts as multicast. Any remaining frame is unicast and touches neither class counter.
- R9: Each completed frame adds 1 to the frame counter and length + 4 to the byte counter. All counters are 32 bits wide and wrap.
- R10: A completed frame sets status bits 0 and 1. Status bits stay set until a 1 is written to the same bit of `stat_clr_i`, and a set in the same cycle wins over a clear.
- R11: A pulse on `base_load_i` sets both the ring base and the pointer to `base_addr_i`.
- R12: A memory request keeps its address, direction and data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable, sampled at frame start |
| base_load_i | input | 1 | Load ring base and pointer |
| base_addr_i | input | 32 | Ring base byte address |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Last byte of frame |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory write byte enables |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | One-cycle acknowledge of the request |
| stat_clr_i | input | 4 | Write-one-to-clear for status bits |
| stat_o | output | 4 | Status: 0 done, 1 normal sum, 2 no descriptor, 3 abnormal sum |
| rx_ptr_o | output | 32 | Current descriptor pointer |
| cnt_bytes_o | output | 32 | Received byte counter |
| cnt_frames_o | output | 32 | Received frame counter |
| cnt_mcast_o | output | 32 | Multicast frame counter |
| cnt_bcast_o | output | 32 | Broadcast frame counter |

## Verification
The assertions assume three things about the inputs. The memory raises `mem_ack_i` for exactly one cycle and only while a request is pending. `base_load_i` is not pulsed while a frame is in flight. Buffers do not wrap past the top of the address space. The bench memory model acknowledges one cycle after it sees a request and drops the acknowledge at the next edge. The base is loaded only between frames, and every buffer sits at a low fixed address well clear of the top.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_RD_SIZE, S_RD_ADDR,
    S_DATA, S_WR_DATA, S_FINISH, S_WR_CTL, S_DISCARD
  } rxd_state_e;

  localparam int ST_DONE = 0;
  localparam int ST_NSUM = 1;
  localparam int ST_NODESC = 2;
  localparam int ST_ASUM = 3;
  localparam int ST_W = 4;

  localparam int CRC_BYTES = 4;
  localparam int RUNT_MIN = 12;
  localparam int DESC_BYTES = 32;
  localparam int ADDR_BYTES = 6;
endpackage

// File: rtl/rxd_classify.sv
module rxd_classify #(
  parameter int IDX_W = 16,
  parameter int NBYTES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  input  logic [7:0]       byte_i,
  output logic             is_mc_o,
  output logic             is_bc_o
);
  logic grp_q, grp_d, allff_q, allff_d;

  always_comb begin
    grp_d = grp_q;
    allff_d = allff_q;
    if (start_i) begin
      grp_d = 1'b0;
      allff_d = 1'b1;
    end else if (byte_vld_i && (byte_idx_i < IDX_W'(NBYTES))) begin
      allff_d = allff_q & (byte_i == 8'hFF);
      if (byte_idx_i == '0) grp_d = byte_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0;
      allff_q <= 1'b1;
    end else begin
      grp_q <= grp_d;
      allff_q <= allff_d;
    end
  end

  assign is_bc_o = allff_q;
  assign is_mc_o = grp_q & ~allff_q;
endmodule

// File: rtl/rxd_stats.sv
module rxd_stats #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] add_bytes_i,
  input  logic             is_mc_i,
  input  logic             is_bc_i,
  output logic [CNT_W-1:0] bytes_o,
  output logic [CNT_W-1:0] frames_o,
  output logic [CNT_W-1:0] mcast_o,
  output logic [CNT_W-1:0] bcast_o
);
  localparam int NCNT = 4;
  logic [NCNT-1:0][CNT_W-1:0] cnt_q, cnt_d;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic en;
    logic [CNT_W-1:0] step;
    if (i == 0) begin : g_bytes
      assign step = CNT_W'(add_bytes_i);
      assign en = inc_i;
    end else if (i == 1) begin : g_frames
      assign step = CNT_W'(1);
      assign en = inc_i;
    end else if (i == 2) begin : g_mc
      assign step = CNT_W'(1);
      assign en = inc_i & is_mc_i;
    end else begin : g_bc
      assign step = CNT_W'(1);
      assign en = inc_i & is_bc_i;
    end
    assign cnt_d[i] = en ? cnt_q[i] + step : cnt_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[i] <= '0;
      else        cnt_q[i] <= cnt_d[i];
    end
  end

  assign bytes_o = cnt_q[0];
  assign frames_o = cnt_q[1];
  assign mcast_o = cnt_q[2];
  assign bcast_o = cnt_q[3];

  // R8
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !(is_mc_i && is_bc_i));
  // R9
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> (frames_o == $past(frames_o) + CNT_W'(1)));
endmodule

// File: rtl/rxd_status.sv
module rxd_status #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d;

  assign stat_d = (stat_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R10
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rxd_writer.sv
module rxd_writer
  import rxd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LEN_W = 16,
  parameter int SIZE_W = 12,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic              base_load_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic              s_valid_i,
  input  logic [7:0]        s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [DW/8-1:0]   mem_be_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic [ST_W-1:0]   stat_clr_i,
  output logic [ST_W-1:0]   stat_o,
  output logic [AW-1:0]     rx_ptr_o,
  output logic [CNT_W-1:0]  cnt_bytes_o,
  output logic [CNT_W-1:0]  cnt_frames_o,
  output logic [CNT_W-1:0]  cnt_mcast_o,
  output logic [CNT_W-1:0]  cnt_bcast_o
);
  localparam int NLANE = DW / 8;
  localparam int LANE_W = $clog2(NLANE);
  localparam int FLD_W = 14;
  localparam int WRAP_BIT = 15;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  rxd_state_e state_q, state_d;
  logic [AW-1:0] base_q, base_d, ptr_q, ptr_d, baddr_q, baddr_d, waddr_q, waddr_d;
  logic [SIZE_W-1:0] bsize_q, bsize_d;
  logic wrap_q, wrap_d, last_q, last_d, refuse_q, refuse_d;
  logic [LEN_W-1:0] len_q, len_d, len_inc;
  logic [DW-1:0] word_q, word_d;
  logic [NLANE-1:0] be_q, be_d;
  logic [LANE_W-1:0] lane;
  logic in_buf, stats_inc, is_mc, is_bc;
  logic [ST_W-1:0] stat_set;
  logic [FLD_W-1:0] tot_len;
  logic [LEN_W-1:0] add_bytes;
  logic unused_rdata;

  assign lane = len_q[LANE_W-1:0];
  assign len_inc = len_q + LEN_W'(1);
  assign in_buf = {{(LEN_W-SIZE_W){1'b0}}, bsize_q} > len_q;
  assign tot_len = len_q[FLD_W-1:0] + FLD_W'(CRC_BYTES);
  assign add_bytes = len_q + LEN_W'(CRC_BYTES);
  assign unused_rdata = ^{mem_rdata_i[DW-2:WRAP_BIT+1], mem_rdata_i[WRAP_BIT-1:SIZE_W]};

  always_comb begin
    state_d = state_q;
    base_d = base_q;
    ptr_d = ptr_q;
    baddr_d = baddr_q;
    waddr_d = waddr_q;
    bsize_d = bsize_q;
    wrap_d = wrap_q;
    last_d = last_q;
    refuse_d = refuse_q;
    len_d = len_q;
    word_d = word_q;
    be_d = be_q;
    stat_set = '0;
    stats_inc = 1'b0;
    s_ready_o = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o = 1'b0;
    mem_addr_o = ptr_q;
    mem_wdata_o = '0;
    mem_be_o = '1;
    case (state_q)
      S_IDLE: begin
        len_d = '0;
        last_d = 1'b0;
        if (s_valid_i) begin
          refuse_d = ~rx_en_i;
          state_d = rx_en_i ? S_RD_CTL : S_DISCARD;
        end
      end
      S_RD_CTL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          refuse_d = 1'b0;
          state_d = mem_rdata_i[DW-1] ? S_RD_SIZE : S_DISCARD;
        end
      end
      S_RD_SIZE: begin
        mem_req_o = 1'b1;
        mem_addr_o = ptr_q + AW'(4);
        if (mem_ack_i) begin
          bsize_d = mem_rdata_i[SIZE_W-1:0];
          wrap_d = mem_rdata_i[WRAP_BIT];
          state_d = S_RD_ADDR;
        end
      end
      S_RD_ADDR: begin
        mem_req_o = 1'b1;
        mem_addr_o = ptr_q + AW'(8);
        if (mem_ack_i) begin
          baddr_d = mem_rdata_i;
          state_d = S_DATA;
        end
      end
      S_DATA: begin
        s_ready_o = 1'b1;
        if (s_valid_i) begin
          word_d[8*lane +: 8] = s_data_i;
          be_d = ((lane == '0) ? '0 : be_q) | (NLANE'(in_buf) << lane);
          len_d = len_inc;
          if ((lane == LANE_W'(NLANE - 1)) || s_last_i) begin
            waddr_d = baddr_q + AW'({len_q[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
            last_d = s_last_i;
            if (be_d != '0)   state_d = S_WR_DATA;
            else if (s_last_i) state_d = S_FINISH;
          end
        end
      end
      S_WR_DATA: begin
        mem_req_o = 1'b1;
        mem_we_o = 1'b1;
        mem_addr_o = waddr_q;
        mem_wdata_o = word_q;
        mem_be_o = be_q;
        if (mem_ack_i) state_d = last_q ? S_FINISH : S_DATA;
      end
      S_FINISH: begin
        if (len_q < LEN_W'(RUNT_MIN)) begin
          stat_set[ST_DONE] = 1'b1;
          stat_set[ST_NSUM] = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_WR_CTL;
        end
      end
      S_WR_CTL: begin
        mem_req_o = 1'b1;
        mem_we_o = 1'b1;
        mem_wdata_o = {2'b00, tot_len, 16'h0300};
        if (mem_ack_i) begin
          ptr_d = wrap_q ? base_q : ptr_q + AW'(DESC_BYTES);
          stats_inc = 1'b1;
          stat_set[ST_DONE] = 1'b1;
          stat_set[ST_NSUM] = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_DISCARD: begin
        s_ready_o = 1'b1;
        if (s_valid_i) begin
          len_d = len_inc;
          if (s_last_i) begin
            state_d = S_IDLE;
            if (!refuse_q) begin
              if (len_inc < LEN_W'(RUNT_MIN)) begin
                stat_set[ST_DONE] = 1'b1;
                stat_set[ST_NSUM] = 1'b1;
              end else begin
                stat_set[ST_NODESC] = 1'b1;
                stat_set[ST_ASUM] = 1'b1;
              end
            end
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (base_load_i) begin
      base_d = base_addr_i;
      ptr_d = base_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= S_IDLE;
      base_q <= '0;
      ptr_q <= '0;
      baddr_q <= '0;
      waddr_q <= '0;
      bsize_q <= '0;
      wrap_q <= 1'b0;
      last_q <= 1'b0;
      refuse_q <= 1'b0;
      len_q <= '0;
      word_q <= '0;
      be_q <= '0;
    end else begin
      state_q <= state_d;
      base_q <= base_d;
      ptr_q <= ptr_d;
      baddr_q <= baddr_d;
      waddr_q <= waddr_d;
      bsize_q <= bsize_d;
      wrap_q <= wrap_d;
      last_q <= last_d;
      refuse_q <= refuse_d;
      len_q <= len_d;
      word_q <= word_d;
      be_q <= be_d;
    end
  end

  assign rx_ptr_o = ptr_q;

  rxd_classify #(.IDX_W(LEN_W), .NBYTES(ADDR_BYTES)) u_class (
    .clk(clk), .rst_n(rst_q_n),
    .start_i(state_q == S_IDLE),
    .byte_vld_i((state_q == S_DATA) && s_valid_i),
    .byte_idx_i(len_q), .byte_i(s_data_i),
    .is_mc_o(is_mc), .is_bc_o(is_bc)
  );

  rxd_stats #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stats (
    .clk(clk), .rst_n(rst_q_n),
    .inc_i(stats_inc), .add_bytes_i(add_bytes),
    .is_mc_i(is_mc), .is_bc_i(is_bc),
    .bytes_o(cnt_bytes_o), .frames_o(cnt_frames_o),
    .mcast_o(cnt_mcast_o), .bcast_o(cnt_bcast_o)
  );

  rxd_status #(.W(ST_W)) u_status (
    .clk(clk), .rst_n(rst_q_n),
    .set_i(stat_set), .clr_i(stat_clr_i), .stat_o(stat_o)
  );

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R4
  ctl_word_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req_o && mem_we_o && mem_be_o == '1 && state_q == S_WR_CTL) |->
      (!mem_wdata_o[DW-1] && mem_wdata_o[9:8] == 2'b11 &&
       mem_wdata_o[29:16] >= 14'(RUNT_MIN + CRC_BYTES)));
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!base_load_i && !(state_q == S_WR_CTL && mem_ack_i)) |=> $stable(rx_ptr_o));
  // R1
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == S_IDLE && s_valid_i && !rx_en_i && !base_load_i) |=>
      (state_q == S_DISCARD && !mem_req_o));
  // R6
  trunc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req_o && state_q == S_WR_DATA) |-> (mem_addr_o < baddr_q + AW'(bsize_q)));
endmodule

// File: tb/sim_rxd_writer.sv
`timescale 1ns/1ps
module sim_rxd_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, base_load = 1'b0;
  logic [31:0] base_addr = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be, stat_clr, stat;
  logic [31:0] rx_ptr, c_bytes, c_frames, c_mc, c_bc;
  logic [31:0] mem [0:255];
  int n_cmp = 0, n_mis = 0, mreq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxd_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .base_load_i(base_load),
    .base_addr_i(base_addr), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_last_i(s_last), .s_ready_o(s_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .stat_clr_i(stat_clr), .stat_o(stat), .rx_ptr_o(rx_ptr),
    .cnt_bytes_o(c_bytes), .cnt_frames_o(c_frames),
    .cnt_mcast_o(c_mc), .cnt_bcast_o(c_bc)
  );

  // memory responder: ack one cycle after request, one-cycle pulse
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        mreq_cnt <= mreq_cnt + 1;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we)
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  // frame table: length, class (0 uni, 1 multi, 2 broad), owned, buffer size, wrap, enable
  localparam int NV = 10;
  localparam int V_LEN  [NV] = '{20, 30, 16, 40,  8, 20, 25, 14, 11, 12};
  localparam int V_KIND [NV] = '{ 0,  1,  2,  0,  0,  0,  1,  2,  0,  0};
  localparam int V_OWN  [NV] = '{ 1,  1,  1,  1,  1,  0,  1,  1,  0,  1};
  localparam int V_BS   [NV] = '{64, 64, 64, 10, 64, 64, 64, 64, 64, 64};
  localparam int V_WRAP [NV] = '{ 0,  0,  0,  0,  0,  0,  1,  0,  0,  0};
  localparam int V_EN   [NV] = '{ 1,  1,  1,  1,  1,  1,  1,  0,  1,  1};
  localparam logic [31:0] BUF = 32'h200;

  function automatic logic [7:0] fbyte(int kind, int i);
    if (i < 6) begin
      if (kind == 2) return 8'hFF;
      if (i == 0) return (kind == 1) ? 8'h01 : 8'h02;
      return 8'(8'h10 + i);
    end
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(int len, int kind);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data = fbyte(kind, i);
      s_last = (i == len - 1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last = 1'b0;
  endtask

  function automatic logic [7:0] mbyte(int a);
    return mem[(a >> 2) & 255][8*(a & 3) +: 8];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_mis++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_ptr, e_bytes, e_frames, e_mc, e_bc, dword, e_stat;
    int dslot, n, m0;
    stat_clr = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R10 reset status", {28'h0, stat}, 32'h0);
    chk("R9 reset frames", c_frames, 32'h0);
    chk("R9 reset bytes", c_bytes, 32'h0);
    chk("R11 reset ptr", rx_ptr, 32'h0);
    chk("R12 reset idle", {30'h0, mem_req, s_ready}, 32'h0);

    base_addr = 32'h0;
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    chk("R11 base load", rx_ptr, 32'h0);
    e_ptr = 0; e_bytes = 0; e_frames = 0; e_mc = 0; e_bc = 0;

    for (int v = 0; v < NV; v++) begin
      stat_clr = 4'hF;
      @(negedge clk);
      stat_clr = 4'h0;
      for (int w = 128; w < 144; w++) mem[w] = 32'hA5A5A5A5;
      dslot = int'(e_ptr >> 2);
      dword = V_OWN[v] ? 32'h8000_0000 : 32'h0;
      mem[dslot] = dword;
      mem[dslot + 1] = {16'h0, V_WRAP[v][0], 3'b000, 12'(V_BS[v])};
      mem[dslot + 2] = BUF;
      rx_en = V_EN[v][0];
      m0 = mreq_cnt;
      send_frame(V_LEN[v], V_KIND[v]);
      repeat (20) @(negedge clk);

      if (!V_EN[v]) begin
        // R1: refused frame, nothing touched
        chk("R1 no memory traffic", 32'(mreq_cnt - m0), 32'h0);
        e_stat = 0;
      end else if (V_LEN[v] < 12) begin
        // R2: runt frame
        chk("R2 runt descriptor untouched", mem[dslot], dword);
        e_stat = 32'h3;
      end else if (!V_OWN[v]) begin
        // R3: no descriptor available
        chk("R3 descriptor untouched", mem[dslot], dword);
        e_stat = 32'hC;
      end else begin
        chk("R4 completion word", mem[dslot],
            ((32'(V_LEN[v] + 4) & 32'h3FFF) << 16) | 32'h300);
        n = (V_LEN[v] < V_BS[v]) ? V_LEN[v] : V_BS[v];
        for (int i = 0; i < n; i++)
          chk("R5 buffer byte", {24'h0, mbyte(int'(BUF) + i)}, {24'h0, fbyte(V_KIND[v], i)});
        chk((n < V_LEN[v]) ? "R6 truncated byte unwritten" : "R5 byte past frame unwritten",
            {24'h0, mbyte(int'(BUF) + n)}, 32'hA5);
        e_ptr = V_WRAP[v] ? 32'h0 : e_ptr + 32;
        e_frames++;
        e_bytes += 32'(V_LEN[v] + 4);
        if (V_KIND[v] == 1) e_mc++;
        if (V_KIND[v] == 2) e_bc++;
        e_stat = 32'h3;
      end
      chk("R10 status after frame", {28'h0, stat}, e_stat);
      chk("R7 pointer", rx_ptr, e_ptr);
      chk("R9 frame count", c_frames, e_frames);
      chk("R9 byte count", c_bytes, e_bytes);
      chk("R8 multicast count", c_mc, e_mc);
      chk("R8 broadcast count", c_bc, e_bc);
    end

    // R10: write-one-to-clear affects only the chosen bit
    stat_clr = 4'b0001;
    @(negedge clk);
    stat_clr = 4'h0;
    @(negedge clk);
    chk("R10 partial clear", {28'h0, stat}, 32'h2);

    // R11: base reload moves pointer between frames
    base_addr = 32'h40;
    base_load = 1'b1;
    @(negedge clk);
    base_load = 1'b0;
    chk("R11 pointer follows base", rx_ptr, 32'h40);

    // R7: wrap now returns to the new base
    mem[16] = 32'h8000_0000;
    mem[17] = {16'h0, 1'b1, 3'b000, 12'd64};
    mem[18] = BUF;
    rx_en = 1'b1;
    send_frame(12, 0);
    repeat (20) @(negedge clk);
    chk("R7 wrap to reloaded base", rx_ptr, 32'h40);
    chk("R4 boundary length", mem[16], (32'd16 << 16) | 32'h300);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule